// File: doc/BRIEF.md
# Strobe-Handshake Queue with Level Flags

This block is a first-in first-out buffer of 64 words of 9 bits that runs on one clock. A producer hands words over with a shift-in strobe and watches an input-ready flag. A consumer takes words with a shift-out strobe and watches an output-ready flag. The oldest stored word always sits on the data outputs. No read enable fetches it. Both strobes are sampled as levels on the system clock, and their rising and falling edges are found internally. A transfer is taken when its strobe rises and is committed when the strobe falls.

A strobe can be held high while the opposite side changes the occupancy. This is what happens when two of these buffers are chained in depth, each one's ready output driving the next one's strobe. In that case the matching ready flag does not simply go high. It gives a pulse of a set number of clock cycles, and the transfer is taken at the end of that pulse. Two occupancy flags are produced: one for half full, and one shared flag that is high when the buffer is nearly empty or nearly full. An active-low master reset clears the buffer.

Top module: `shift_fifo`

## Requirements
- R1: While reset is low, in_ready is 1, out_ready is 0, data_out is all zeros, half_full is 0 and margin_flag is 1.
- R2: When in_ready is high, a rising shift_in stores data_in and clears in_ready at the next clock. The falling shift_in commits the word, and in_ready returns to 1 at that clock unless 64 words are now stored.
- R3: With 64 words stored, in_ready stays 0 and shift_in pulses store nothing. The occupancy never goes above 64.
- R4: While out_ready is high, data_out does not change. A rising shift_out clears out_ready at the next clock and leaves data_out as it was. The falling shift_out removes the word, and at that clock the next stored word appears on data_out with out_ready at 1.
- R5: When the last word is removed, out_ready stays 0 and data_out keeps the last word removed.
- R6: A word committed into an empty buffer while shift_out is low appears on data_out at the commit clock. out_ready goes to 1 and stays there until shift_out rises.
- R7: A word committed into an empty buffer while shift_out is held high raises out_ready for exactly PULSE clock cycles (default 2), and that word is then counted as taken. A second word written during that time stays hidden, with out_ready at 0 and data_out unchanged, until shift_out falls. At that clock the second word is shown.
- R8: Removing a word from a full buffer while shift_in is low sets in_ready to 1, and it stays at 1 until shift_in rises.
- R9: Removing a word from a full buffer while shift_in is held high raises in_ready for exactly PULSE cycles. At the end of the pulse data_in is stored, and the word is committed when shift_in falls.
- R10: half_full is 1 exactly when 32 or more words are stored.
- R11: margin_flag is 1 exactly when 8 or fewer words are stored, or 56 or more.
- R12: If shift_in is high when reset is released, data_in is stored at the first clock and in_ready stays 0 until shift_in falls. If shift_in is low at release, in_ready stays 1 and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| shift_in | input | 1 | Write strobe: rise takes data_in, fall commits |
| data_in | input | 9 | Word to store |
| in_ready | output | 1 | Buffer can take a word |
| shift_out | input | 1 | Read strobe: rise claims the head, fall removes it |
| out_ready | output | 1 | data_out holds a valid unread word |
| data_out | output | 9 | Head word, or last word read when empty |
| half_full | output | 1 | 32 or more words stored |
| margin_flag | output | 1 | 8 or fewer, or 56 or more, words stored |

## Verification
The hardest cases to reach are the two held-strobe pulses. The bubblethrough pulse needs a buffer filled to exactly 64 words, with shift_in already high before a word is removed. The bench fills the buffer through the port, raises shift_in with a marker word, removes one word, and counts the cycles in_ready stays high. It then drains all 64 words to confirm the marker was stored last and that the word offered while the buffer was full is absent. The fallthrough pulse is reached by holding shift_out high on an empty buffer before writing. Each flag threshold is crossed in both directions by the table walk, which reaches 64 words and comes back to empty.

// File: rtl/shift_fifo_pkg.sv
package shift_fifo_pkg;

   // Bits needed to hold a value in the range 0..n.
   function automatic int span_bits(input int n);
      int b;
      b = 1;
      while ((1 << b) <= n) b++;
      return b;
   endfunction

   localparam int DEF_DEPTH = 64;
   localparam int DEF_WIDTH = 9;
   localparam int DEF_PULSE = 2;
   localparam int DEF_GAP   = 8;

endpackage

// File: rtl/shift_fifo_port.sv
// One strobe/ready handshake side: edge detection, take/commit, ready pulse.
module shift_fifo_port
   import shift_fifo_pkg::*;
#(
   parameter int PULSE    = DEF_PULSE,
   parameter bit RDY_INIT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic room_next,
   output logic take,
   output logic done,
   output logic rdy,
   output logic rdy_rise
);
   localparam int PW = span_bits(PULSE);

   logic          strobe_q;
   logic          pend_q;
   logic          rdy_q;
   logic [PW-1:0] hold_q;
   logic          pend_n;
   logic          rdy_n;

   assign take     = strobe & rdy_q & (hold_q == '0);
   assign done     = ~strobe & strobe_q & pend_q;
   assign pend_n   = take | (pend_q & ~done);
   assign rdy_n    = ~pend_n & room_next;
   assign rdy_rise = rdy_n & ~rdy_q;
   assign rdy      = rdy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         pend_q   <= 1'b0;
         rdy_q    <= RDY_INIT;
         hold_q   <= '0;
      end else begin
         strobe_q <= strobe;
         pend_q   <= pend_n;
         rdy_q    <= rdy_n;
         if (!rdy_n)
            hold_q <= '0;
         else if (rdy_rise && strobe)
            hold_q <= PW'(PULSE - 1);
         else if (hold_q != '0)
            hold_q <= hold_q - 1'b1;
      end
   end
endmodule

// File: rtl/shift_fifo_store.sv
// Word storage with write and read pointers; presents the next head word.
module shift_fifo_store
   import shift_fifo_pkg::*;
#(
   parameter int DEPTH = DEF_DEPTH,
   parameter int WIDTH = DEF_WIDTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             wr_adv,
   input  logic             rd_adv,
   output logic [WIDTH-1:0] head_next
);
   localparam int AW = $clog2(DEPTH);

   logic [AW-1:0]    wptr_q;
   logic [AW-1:0]    rptr_q;
   logic [AW-1:0]    rptr_n;
   logic [WIDTH-1:0] words [DEPTH];

   assign rptr_n    = rd_adv ? rptr_q + 1'b1 : rptr_q;
   assign head_next = words[rptr_n];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
      end else begin
         if (wr_adv) wptr_q <= wptr_q + 1'b1;
         rptr_q <= rptr_n;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      always_ff @(posedge clk) begin
         if (wr_en && wptr_q == AW'(i))
            words[i] <= wr_data;
      end
   end
endmodule

// File: rtl/shift_fifo_flags.sv
// Registered occupancy flags derived from the next-cycle level.
module shift_fifo_flags
   import shift_fifo_pkg::*;
#(
   parameter int DEPTH = DEF_DEPTH,
   parameter int GAP   = DEF_GAP
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [span_bits(DEPTH)-1:0] level_n,
   output logic                        half,
   output logic                        margin
);
   localparam int LW = span_bits(DEPTH);
   localparam logic [LW-1:0] HALF_LVL = LW'(DEPTH / 2);
   localparam logic [LW-1:0] LOW_LVL  = LW'(GAP);
   localparam logic [LW-1:0] HIGH_LVL = LW'(DEPTH - GAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half   <= 1'b0;
         margin <= 1'b1;
      end else begin
         half   <= (level_n >= HALF_LVL);
         margin <= (level_n <= LOW_LVL) || (level_n >= HIGH_LVL);
      end
   end
endmodule

// File: rtl/shift_fifo.sv
module shift_fifo
   import shift_fifo_pkg::*;
#(
   parameter int DEPTH = DEF_DEPTH,
   parameter int WIDTH = DEF_WIDTH,
   parameter int PULSE = DEF_PULSE,
   parameter int GAP   = DEF_GAP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_in,
   input  logic [WIDTH-1:0] data_in,
   output logic             in_ready,
   input  logic             shift_out,
   output logic             out_ready,
   output logic [WIDTH-1:0] data_out,
   output logic             half_full,
   output logic             margin_flag
);
   localparam int LW = span_bits(DEPTH);
   localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 4) begin : g_bad_depth
      $error("shift_fifo: DEPTH must be a power of two of at least 4");
   end
   if (PULSE < 1) begin : g_bad_pulse
      $error("shift_fifo: PULSE must be at least 1");
   end
   if (GAP < 1 || 2 * GAP >= DEPTH) begin : g_bad_gap
      $error("shift_fifo: GAP must lie between 1 and DEPTH/2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("shift_fifo: WIDTH must be positive");
   end

   logic [LW-1:0]    level;
   logic [LW-1:0]    level_n;
   logic             w_take, w_done, w_rise;
   logic             r_take, r_done, r_rise;
   logic [WIDTH-1:0] head_next;

   always_comb begin
      level_n = level;
      if (w_done && !r_done)      level_n = level + 1'b1;
      else if (r_done && !w_done) level_n = level - 1'b1;
   end

   shift_fifo_port #(.PULSE(PULSE), .RDY_INIT(1'b1)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (shift_in),
      .room_next (level_n < FULL_LVL),
      .take      (w_take),
      .done      (w_done),
      .rdy       (in_ready),
      .rdy_rise  (w_rise)
   );

   shift_fifo_port #(.PULSE(PULSE), .RDY_INIT(1'b0)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (shift_out),
      .room_next (level_n != '0),
      .take      (r_take),
      .done      (r_done),
      .rdy       (out_ready),
      .rdy_rise  (r_rise)
   );

   shift_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (w_take),
      .wr_data   (data_in),
      .wr_adv    (w_done),
      .rd_adv    (r_done),
      .head_next (head_next)
   );

   shift_fifo_flags #(.DEPTH(DEPTH), .GAP(GAP)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_n (level_n),
      .half    (half_full),
      .margin  (margin_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level    <= '0;
         data_out <= '0;
      end else begin
         level <= level_n;
         if (r_rise) data_out <= head_next;
      end
   end
endmodule

// File: rtl/shift_fifo_chk.sv
module shift_fifo_chk
   import shift_fifo_pkg::*;
#(
   parameter int DEPTH = DEF_DEPTH,
   parameter int WIDTH = DEF_WIDTH,
   parameter int GAP   = DEF_GAP
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        shift_in,
   input logic                        shift_out,
   input logic                        in_ready,
   input logic                        out_ready,
   input logic [WIDTH-1:0]            data_out,
   input logic                        half_full,
   input logic                        margin_flag,
   input logic [span_bits(DEPTH)-1:0] level
);
   localparam int LW = span_bits(DEPTH);
   localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
   localparam logic [LW-1:0] HALF_LVL = LW'(DEPTH / 2);
   localparam logic [LW-1:0] LOW_LVL  = LW'(GAP);
   localparam logic [LW-1:0] HIGH_LVL = LW'(DEPTH - GAP);

   assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      level <= FULL_LVL);

   assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> level < FULL_LVL);

   assert_empty_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_ready |-> level != '0);

   assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ready && $past(out_ready)) |-> $stable(data_out));

   assert_out_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_ready) |-> $past(shift_out));

   assert_in_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ready) |-> $past(shift_in));

   assert_half_R10: assert property (@(posedge clk) disable iff (!rst_n)
      half_full == (level >= HALF_LVL));

   assert_margin_R11: assert property (@(posedge clk) disable iff (!rst_n)
      margin_flag == ((level <= LOW_LVL) || (level >= HIGH_LVL)));
endmodule

bind shift_fifo shift_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .GAP(GAP)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .shift_in    (shift_in),
   .shift_out   (shift_out),
   .in_ready    (in_ready),
   .out_ready   (out_ready),
   .data_out    (data_out),
   .half_full   (half_full),
   .margin_flag (margin_flag),
   .level       (level)
);

// File: tb/tb_shift_fifo.sv
module tb_shift_fifo;
   localparam int DEPTH = 64;
   localparam int W     = 9;
   localparam int PULSE = 2;
   localparam int NPLAN = 14;

   // {push(1)/pop(0), count[6:0], expected half, expected margin}
   localparam logic [9:0] PLAN [NPLAN] = '{
      {1'b1, 7'd8,  1'b0, 1'b1}, {1'b1, 7'd1,  1'b0, 1'b0},
      {1'b1, 7'd22, 1'b0, 1'b0}, {1'b1, 7'd1,  1'b1, 1'b0},
      {1'b1, 7'd23, 1'b1, 1'b0}, {1'b1, 7'd1,  1'b1, 1'b1},
      {1'b1, 7'd8,  1'b1, 1'b1}, {1'b0, 7'd8,  1'b1, 1'b1},
      {1'b0, 7'd1,  1'b1, 1'b0}, {1'b0, 7'd23, 1'b1, 1'b0},
      {1'b0, 7'd1,  1'b0, 1'b0}, {1'b0, 7'd22, 1'b0, 1'b0},
      {1'b0, 7'd1,  1'b0, 1'b1}, {1'b0, 7'd8,  1'b0, 1'b1}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         shift_in = 1'b0;
   logic         shift_out = 1'b0;
   logic [W-1:0] data_in = '0;
   logic         in_ready, out_ready, half_full, margin_flag;
   logic [W-1:0] data_out;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] model [256];
   int head = 0;
   int tail = 0;
   int seed = 5;
   logic [W-1:0] last;

   always #4 clk = ~clk;

   shift_fifo dut (
      .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .data_in(data_in),
      .in_ready(in_ready), .shift_out(shift_out), .out_ready(out_ready),
      .data_out(data_out), .half_full(half_full), .margin_flag(margin_flag)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic push(input logic [W-1:0] d);
      data_in  = d;
      shift_in = 1'b1;
      @(negedge clk);
      shift_in = 1'b0;
      @(negedge clk);
   endtask

   task automatic push_model(input logic [W-1:0] d);
      push(d);
      model[tail % 256] = d;
      tail++;
   endtask

   task automatic pop_model();
      check("R4 head valid", int'(out_ready), 1);
      check("R4 head word", int'(data_out), int'(model[head % 256]));
      last = data_out;
      shift_out = 1'b1;
      @(negedge clk);
      check("R4 ready drops, word held", int'({out_ready, data_out}), int'({1'b0, last}));
      shift_out = 1'b0;
      @(negedge clk);
      head++;
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 in_ready", int'(in_ready), 1);
      check("R1 out_ready", int'(out_ready), 0);
      check("R1 data_out", int'(data_out), 0);
      check("R1 half_full", int'(half_full), 0);
      check("R1 margin_flag", int'(margin_flag), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: fill to 64 and drain, flags at every threshold (R10, R11)
      for (int e = 0; e < NPLAN; e++) begin
         for (int k = 0; k < int'(PLAN[e][8:2]); k++) begin
            if (PLAN[e][9]) begin
               seed = (seed * 37 + 11) % 512;
               push_model(W'(seed));
               check("R2 in_ready after commit", int'(in_ready), (tail - head) < DEPTH ? 1 : 0);
               if (tail - head == 1)
                  check("R6 fallthrough word", int'({out_ready, data_out}), int'({1'b1, model[head % 256]}));
            end else begin
               pop_model();
            end
         end
         check("R10 half_full", int'(half_full), int'(PLAN[e][1]));
         check("R11 margin_flag", int'(margin_flag), int'(PLAN[e][0]));
      end
      // R5: empty after last read keeps last word
      check("R5 out_ready empty", int'(out_ready), 0);
      check("R5 last word kept", int'(data_out), int'(last));

      // R3: full buffer ignores shift_in
      for (int k = 0; k < DEPTH; k++) push_model(W'(k + 64));
      check("R3 full in_ready", int'(in_ready), 0);
      push(9'h1AA);
      check("R3 ignored pulse", int'(in_ready), 0);

      // R8: bubblethrough with shift_in low
      pop_model();
      check("R8 in_ready up", int'(in_ready), 1);
      repeat (3) @(negedge clk);
      check("R8 in_ready stays", int'(in_ready), 1);
      push_model(9'h0F0);
      check("R3 full again", int'(in_ready), 0);

      // R9: bubblethrough with shift_in held high
      data_in  = 9'h0C3;
      shift_in = 1'b1;
      @(negedge clk);
      pop_model();
      begin
         int hi;
         hi = 0;
         while (in_ready && hi < 10) begin
            hi++;
            @(negedge clk);
         end
         check("R9 pulse width", hi, PULSE);
      end
      model[tail % 256] = 9'h0C3;
      tail++;
      shift_in = 1'b0;
      @(negedge clk);
      check("R9 full after commit", int'(in_ready), 0);
      while (tail != head) pop_model();   // order check also proves R3 drop
      check("R5 empty", int'(out_ready), 0);

      // R7: fallthrough with shift_out held high
      shift_out = 1'b1;
      @(negedge clk);
      push(9'h111);
      begin
         int hi;
         hi = 0;
         while (out_ready && hi < 10) begin
            hi++;
            @(negedge clk);
         end
         check("R7 pulse width", hi, PULSE);
      end
      check("R7 word shown", int'(data_out), 9'h111);
      push(9'h122);
      check("R7 second hidden", int'({out_ready, data_out}), int'({1'b0, 9'h111}));
      shift_out = 1'b0;
      @(negedge clk);
      check("R7 second shown", int'({out_ready, data_out}), int'({1'b1, 9'h122}));

      // R12: reset released with shift_in high
      rst_n    = 1'b0;
      data_in  = 9'h055;
      shift_in = 1'b1;
      @(negedge clk);
      check("R1 reset clears", int'({out_ready, data_out}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 immediate take", int'(in_ready), 0);
      shift_in = 1'b0;
      @(negedge clk);
      check("R12 word stored", int'({in_ready, out_ready, data_out}), int'({2'b11, 9'h055}));

      // R12: reset released with shift_in low
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R12 no take", int'({in_ready, out_ready}), 2);

      summary();
      $finish;
   end
endmodule